// File: doc/BRIEF.md
# Dual-Bank Audio Port Register File

This block is the register file of one audio data port in a peripheral on a two-wire, multi-drop audio bus. Each transport parameter (channel enables, sample interval, the two offsets, both block-control bytes, the horizontal start/stop byte, lane control and the frame-shape byte) is held twice, in bank 0 and bank 1. Only the active bank drives the exported parameters. Software fills the inactive bank while audio keeps running from the active one. It then writes the frame-shape byte of the inactive bank, and at the next frame-sync pulse both banks swap roles in one cycle. Port control and word length are held once and are not banked.

Register access uses a request channel (`acc_*`) and a read-response channel (`rsp_*`). Both are valid/ready. A request transfers on a cycle where `acc_valid` and `acc_ready` are both high. `acc_ready` is low only while a read response is held unaccepted, which is the case when `rsp_valid` is high and `rsp_ready` is low. A response stays valid, with its data stable, until `rsp_ready` is seen high. Writes produce no response.

The frame-shape byte is decoded into row and column counts for the active bank. Writes to the active bank take effect on the exported parameters at once.

Top module: `dport_bank_regfile`

## Requirements
- R1: After reset, bank 0 is active, no switch is pending, every register of both banks reads 0, and the frame shape decodes to 48 rows and 2 columns.
- R2: The address map places the unbanked registers at 0x00 (port control) and 0x01 (word length). Bank 0 sits at 0x10 to 0x19 and bank 1 at 0x20 to 0x29, with these offsets: +0 frame shape, +1 channel enable, +2 sample-interval low byte, +3 sample-interval high byte, +4 offset 1, +5 offset 2, +6 block group, +7 block packing, +8 horizontal control, +9 lane control. A read returns the addressed register one cycle after it is accepted. Unmapped addresses read 0.
- R3: A write to the inactive bank leaves every exported active parameter unchanged.
- R4: A write to the frame-shape register of the inactive bank sets `switch_pending`. At the next cycle with `frame_sync` high, `active_bank` flips and `switch_pending` clears.
- R5: A `frame_sync` pulse with no switch pending changes nothing. A write to the frame-shape register of the active bank does not arm a switch.
- R6: If the inactive frame-shape register is written more than once before frame sync, the last value written is the one decoded after the switch.
- R7: Frame-shape bits [2:0] are a column index. Indices 0 to 7 give 2, 4, 6, 8, 10, 12, 14 and 16 columns.
- R8: Frame-shape bits [7:3] are a row index. Indices 0 to 23 give 48, 50, 60, 64, 75, 80, 125, 147, 96, 100, 120, 128, 150, 160, 250, 0, 192, 200, 240, 256, 72, 144, 90 and 180 rows. Index 15 and indices 24 to 31 give 0.
- R9: The sample interval is stored minus one. It is exported as {high byte, low byte}. The horizontal-control byte exports hstart from bits [7:4] and hstop from bits [3:0].
- R10: In port control, bits [1:0] are the flow mode and bits [3:2] are the data mode. Bits [7:4] read as 0. Word length holds bits per sample minus one, in 8 bits.
- R11: When `PORT_NUM` is 0, writes to the block-packing register of either bank are ignored, and it reads and exports 0.
- R12: While a read response is held unaccepted, `acc_ready` is low, the response data stays stable, and a request presented during that time is not performed.
- R13: After a switch, the newly inactive bank keeps its contents until it is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | One-cycle pulse at each frame boundary |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request can be taken |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Register address |
| acc_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_data | output | 8 | Read data |
| active_bank | output | 1 | Bank currently driving the parameters |
| switch_pending | output | 1 | Bank switch armed for next frame sync |
| frame_rows | output | 9 | Decoded row count of the active bank |
| frame_cols | output | 5 | Decoded column count of the active bank |
| act_ch_en | output | 8 | Active channel-enable mask |
| act_sample_interval | output | 16 | Active sample interval minus one |
| act_offset1 | output | 8 | Active offset 1 |
| act_offset2 | output | 8 | Active offset 2 |
| act_blk_grp | output | 8 | Active block-group control |
| act_blk_pkg | output | 8 | Active block-packing control |
| act_hstart | output | 4 | Active horizontal start |
| act_hstop | output | 4 | Active horizontal stop |
| act_lane | output | 8 | Active lane control |
| port_data_mode | output | 2 | Data mode |
| port_flow_mode | output | 2 | Flow mode |
| word_len | output | 8 | Bits per sample minus one |

## Verification
The assertions assume that `frame_sync` is a clean synchronous pulse and that requests follow the valid/ready rules. They do not assume that `rsp_ready` ever rises. The check that inactive-bank writes have no effect leaves out the cycles where a frame sync coincides with the write, because a switch may legally change the outputs in those cycles. The directed tasks drive every input on the falling edge. They issue frame-sync pulses only in cycles with no access pending, and they hold a stalled request for a single cycle, so the stimulus stays within those assumptions.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_BANKS = 2;
  localparam int IDX_W     = 4;
  localparam int LAST_IDX  = 9;

  localparam logic [IDX_W-1:0] IX_FSHAPE = 4'd0;
  localparam logic [IDX_W-1:0] IX_CHEN   = 4'd1;
  localparam logic [IDX_W-1:0] IX_SI_LO  = 4'd2;
  localparam logic [IDX_W-1:0] IX_SI_HI  = 4'd3;
  localparam logic [IDX_W-1:0] IX_OFF1   = 4'd4;
  localparam logic [IDX_W-1:0] IX_OFF2   = 4'd5;
  localparam logic [IDX_W-1:0] IX_BGRP   = 4'd6;
  localparam logic [IDX_W-1:0] IX_BPKG   = 4'd7;
  localparam logic [IDX_W-1:0] IX_HCTL   = 4'd8;
  localparam logic [IDX_W-1:0] IX_LANE   = 4'd9;

  typedef struct packed {
    logic [REG_W-1:0]   fshape;
    logic [REG_W-1:0]   chen;
    logic [2*REG_W-1:0] sint;
    logic [REG_W-1:0]   off1;
    logic [REG_W-1:0]   off2;
    logic [REG_W-1:0]   bgrp;
    logic [REG_W-1:0]   bpkg;
    logic [REG_W-1:0]   hctl;
    logic [REG_W-1:0]   lane;
  } bank_t;

  function automatic logic [8:0] row_count(input logic [4:0] idx);
    case (idx)
      5'd0:  return 9'd48;
      5'd1:  return 9'd50;
      5'd2:  return 9'd60;
      5'd3:  return 9'd64;
      5'd4:  return 9'd75;
      5'd5:  return 9'd80;
      5'd6:  return 9'd125;
      5'd7:  return 9'd147;
      5'd8:  return 9'd96;
      5'd9:  return 9'd100;
      5'd10: return 9'd120;
      5'd11: return 9'd128;
      5'd12: return 9'd150;
      5'd13: return 9'd160;
      5'd14: return 9'd250;
      5'd16: return 9'd192;
      5'd17: return 9'd200;
      5'd18: return 9'd240;
      5'd19: return 9'd256;
      5'd20: return 9'd72;
      5'd21: return 9'd144;
      5'd22: return 9'd90;
      5'd23: return 9'd180;
      default: return 9'd0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] field_read(input bank_t b, input logic [IDX_W-1:0] ix);
    case (ix)
      IX_FSHAPE: return b.fshape;
      IX_CHEN:   return b.chen;
      IX_SI_LO:  return b.sint[REG_W-1:0];
      IX_SI_HI:  return b.sint[2*REG_W-1:REG_W];
      IX_OFF1:   return b.off1;
      IX_OFF2:   return b.off2;
      IX_BGRP:   return b.bgrp;
      IX_BPKG:   return b.bpkg;
      IX_HCTL:   return b.hctl;
      IX_LANE:   return b.lane;
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/dpr_bank.sv
module dpr_bank
  import dpr_pkg::*;
#(
  parameter bit HAS_BPKG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wr_data,
  output bank_t            regs
);
  bank_t q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en) begin
      case (wr_idx)
        IX_FSHAPE: q.fshape <= wr_data;
        IX_CHEN:   q.chen <= wr_data;
        IX_SI_LO:  q.sint[REG_W-1:0] <= wr_data;
        IX_SI_HI:  q.sint[2*REG_W-1:REG_W] <= wr_data;
        IX_OFF1:   q.off1 <= wr_data;
        IX_OFF2:   q.off2 <= wr_data;
        IX_BGRP:   q.bgrp <= wr_data;
        IX_BPKG:   if (HAS_BPKG) q.bpkg <= wr_data;
        IX_HCTL:   q.hctl <= wr_data;
        IX_LANE:   q.lane <= wr_data;
        default:   ;
      endcase
    end
  end

  assign regs = q;
endmodule

// File: rtl/dpr_frame_shape.sv
module dpr_frame_shape
  import dpr_pkg::*;
(
  input  logic [REG_W-1:0] fshape,
  output logic [8:0]       rows,
  output logic [4:0]       cols
);
  assign rows = row_count(fshape[7:3]);
  assign cols = ({2'b00, fshape[2:0]} + 5'd1) << 1;
endmodule

// File: rtl/dport_bank_regfile.sv
module dport_bank_regfile
  import dpr_pkg::*;
#(
  parameter int PORT_NUM = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_sync,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic             acc_write,
  input  logic [7:0]       acc_addr,
  input  logic [REG_W-1:0] acc_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [REG_W-1:0] rsp_data,
  output logic             active_bank,
  output logic             switch_pending,
  output logic [8:0]       frame_rows,
  output logic [4:0]       frame_cols,
  output logic [REG_W-1:0] act_ch_en,
  output logic [15:0]      act_sample_interval,
  output logic [REG_W-1:0] act_offset1,
  output logic [REG_W-1:0] act_offset2,
  output logic [REG_W-1:0] act_blk_grp,
  output logic [REG_W-1:0] act_blk_pkg,
  output logic [3:0]       act_hstart,
  output logic [3:0]       act_hstop,
  output logic [REG_W-1:0] act_lane,
  output logic [1:0]       port_data_mode,
  output logic [1:0]       port_flow_mode,
  output logic [REG_W-1:0] word_len
);
  localparam bit HAS_BPKG = (PORT_NUM != 0);
  localparam logic [3:0] PAGE_GLOBAL = 4'h0;
  localparam logic [3:0] PAGE_BANK0  = 4'h1;
  localparam logic [3:0] PAGE_BANK1  = 4'h2;

  logic [3:0]       page;
  logic [IDX_W-1:0] idx;
  logic             fire, wr, rd;
  logic             bank_hit, sel_bank, arm, do_switch;
  logic [3:0]       pctl_q;
  logic [REG_W-1:0] wlen_q;
  logic [REG_W-1:0] rd_val;
  bank_t            bank_q [NUM_BANKS];
  bank_t            act;

  assign page      = acc_addr[7:4];
  assign idx       = acc_addr[3:0];
  assign acc_ready = !rsp_valid || rsp_ready;
  assign fire      = acc_valid && acc_ready;
  assign wr        = fire && acc_write;
  assign rd        = fire && !acc_write;
  assign bank_hit  = (page == PAGE_BANK0 || page == PAGE_BANK1) && (idx <= 4'(LAST_IDX));
  assign sel_bank  = (page == PAGE_BANK1);
  assign arm       = wr && bank_hit && (idx == IX_FSHAPE) && (sel_bank != active_bank);
  assign do_switch = frame_sync && switch_pending;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    dpr_bank #(.HAS_BPKG(HAS_BPKG)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr && bank_hit && (sel_bank == 1'(g))),
      .wr_idx  (idx),
      .wr_data (acc_wdata),
      .regs    (bank_q[g])
    );
  end

  // Bank-swap control: a switch in the same cycle as an arming write
  // makes the written bank active, so that write leaves nothing armed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_bank    <= 1'b0;
      switch_pending <= 1'b0;
    end else begin
      if (do_switch) active_bank <= !active_bank;
      switch_pending <= do_switch ? 1'b0 : (switch_pending || arm);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pctl_q <= '0;
      wlen_q <= '0;
    end else if (wr && page == PAGE_GLOBAL) begin
      if (idx == 4'd0) pctl_q <= acc_wdata[3:0];
      if (idx == 4'd1) wlen_q <= acc_wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (bank_hit) begin
      rd_val = field_read(bank_q[sel_bank], idx);
    end else if (page == PAGE_GLOBAL) begin
      if (idx == 4'd0) rd_val = {4'b0000, pctl_q};
      if (idx == 4'd1) rd_val = wlen_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign act = bank_q[active_bank];

  dpr_frame_shape u_shape (
    .fshape (act.fshape),
    .rows   (frame_rows),
    .cols   (frame_cols)
  );

  assign act_ch_en           = act.chen;
  assign act_sample_interval = act.sint;
  assign act_offset1         = act.off1;
  assign act_offset2         = act.off2;
  assign act_blk_grp         = act.bgrp;
  assign act_blk_pkg         = act.bpkg;
  assign act_hstart          = act.hctl[7:4];
  assign act_hstop           = act.hctl[3:0];
  assign act_lane            = act.lane;
  assign port_flow_mode      = pctl_q[1:0];
  assign port_data_mode      = pctl_q[3:2];
  assign word_len            = wlen_q;
endmodule

// File: rtl/dport_bank_checker.sv
module dport_bank_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_sync,
  input logic       acc_valid,
  input logic       acc_ready,
  input logic       acc_write,
  input logic [7:0] acc_addr,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       active_bank,
  input logic       switch_pending,
  input logic [7:0] act_ch_en
);
  logic inactive_wr;
  assign inactive_wr = acc_valid && acc_ready && acc_write &&
                       (acc_addr[7:4] == (active_bank ? 4'h1 : 4'h2));

  // R4: an armed switch is taken at the frame-sync cycle
  assert_switch_on_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (switch_pending && frame_sync) |=> (active_bank != $past(active_bank)) && !switch_pending);

  // R4: arming only ever follows an accepted write
  assert_arm_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(switch_pending) |-> $past(acc_valid && acc_ready && acc_write));

  // R5: the active bank never changes without a frame sync
  assert_bank_moves_on_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_bank) |-> $past(frame_sync));

  // R3: writing the inactive bank does not disturb active channel enables
  assert_inactive_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inactive_wr && !frame_sync) |=> $stable(act_ch_en));

  // R12: a stalled response holds its data
  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data));

  // R2: an accepted read yields a response next cycle
  assert_read_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && !acc_write) |=> rsp_valid);
endmodule

bind dport_bank_regfile dport_bank_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .frame_sync     (frame_sync),
  .acc_valid      (acc_valid),
  .acc_ready      (acc_ready),
  .acc_write      (acc_write),
  .acc_addr       (acc_addr),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_data       (rsp_data),
  .active_bank    (active_bank),
  .switch_pending (switch_pending),
  .act_ch_en      (act_ch_en)
);

// File: tb/tb_dport_bank_regfile.sv
`timescale 1ns/1ps
module tb_dport_bank_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_sync = 1'b0;
  logic       acc_valid = 1'b0;
  logic       acc_write = 1'b0;
  logic [7:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic       rsp_ready = 1'b1;

  logic       acc_ready, rsp_valid, active_bank, switch_pending;
  logic [7:0] rsp_data, act_ch_en, act_offset1, act_offset2, act_blk_grp, act_blk_pkg, act_lane, word_len;
  logic [8:0] frame_rows;
  logic [4:0] frame_cols;
  logic [15:0] act_sample_interval;
  logic [3:0] act_hstart, act_hstop;
  logic [1:0] port_data_mode, port_flow_mode;

  logic       z_acc_ready, z_rsp_valid, z_active_bank, z_switch_pending;
  logic [7:0] z_rsp_data, z_act_ch_en, z_act_offset1, z_act_offset2, z_act_blk_grp, z_act_blk_pkg, z_act_lane, z_word_len;
  logic [8:0] z_frame_rows;
  logic [4:0] z_frame_cols;
  logic [15:0] z_act_sample_interval;
  logic [3:0] z_act_hstart, z_act_hstop;
  logic [1:0] z_port_data_mode, z_port_flow_mode;

  int checks = 0;
  int errors = 0;

  localparam logic [7:0] B0 = 8'h10;
  localparam logic [7:0] B1 = 8'h20;

  always #2.5 clk = ~clk;

  dport_bank_regfile #(.PORT_NUM(1)) dut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .active_bank(active_bank), .switch_pending(switch_pending),
    .frame_rows(frame_rows), .frame_cols(frame_cols),
    .act_ch_en(act_ch_en), .act_sample_interval(act_sample_interval),
    .act_offset1(act_offset1), .act_offset2(act_offset2),
    .act_blk_grp(act_blk_grp), .act_blk_pkg(act_blk_pkg),
    .act_hstart(act_hstart), .act_hstop(act_hstop), .act_lane(act_lane),
    .port_data_mode(port_data_mode), .port_flow_mode(port_flow_mode),
    .word_len(word_len)
  );

  dport_bank_regfile #(.PORT_NUM(0)) dut0 (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .acc_valid(acc_valid), .acc_ready(z_acc_ready), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rsp_valid(z_rsp_valid), .rsp_ready(rsp_ready), .rsp_data(z_rsp_data),
    .active_bank(z_active_bank), .switch_pending(z_switch_pending),
    .frame_rows(z_frame_rows), .frame_cols(z_frame_cols),
    .act_ch_en(z_act_ch_en), .act_sample_interval(z_act_sample_interval),
    .act_offset1(z_act_offset1), .act_offset2(z_act_offset2),
    .act_blk_grp(z_act_blk_grp), .act_blk_pkg(z_act_blk_pkg),
    .act_hstart(z_act_hstart), .act_hstop(z_act_hstop), .act_lane(z_act_lane),
    .port_data_mode(z_port_data_mode), .port_flow_mode(z_port_flow_mode),
    .word_len(z_word_len)
  );

  function automatic int exp_rows(input int r);
    int t [24] = '{48, 50, 60, 64, 75, 80, 125, 147, 96, 100, 120, 128,
                   150, 160, 250, 0, 192, 200, 240, 256, 72, 144, 90, 180};
    if (r < 24) return t[r];
    return 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
    d = rsp_data;
    if (!rsp_valid) d = 8'hxx;
  endtask

  task automatic sync_pulse();
    @(negedge clk);
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 active bank", active_bank, 0);
    chk("R1 pending", switch_pending, 0);
    chk("R1 ch_en", act_ch_en, 0);
    chk("R1 rows", frame_rows, 48);
    chk("R1 cols", frame_cols, 2);
    rd(B1 + 8'd1, d);
    chk("R1 bank1 ch_en", d, 0);
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    wr(B0 + 8'd2, 8'h2F);
    wr(B0 + 8'd3, 8'h01);
    chk("R9 sample interval", act_sample_interval, 16'h012F);
    wr(B0 + 8'd8, 8'hA5);
    chk("R9 hstart", act_hstart, 4'hA);
    chk("R9 hstop", act_hstop, 4'h5);
    wr(B0 + 8'd4, 8'h33);
    chk("R2 offset1", act_offset1, 8'h33);
    wr(8'h00, 8'hFE);
    rd(8'h00, d);
    chk("R10 port ctrl readback", d, 8'h0E);
    chk("R10 data mode", port_data_mode, 3);
    chk("R10 flow mode", port_flow_mode, 2);
    wr(8'h01, 8'h17);
    chk("R10 word len", word_len, 8'h17);
    rd(B0 + 8'd2, d);
    chk("R2 readback si lo", d, 8'h2F);
    rd(8'h3C, d);
    chk("R2 unmapped read", d, 0);
  endtask

  task automatic t_inactive();
    logic [7:0] d;
    wr(B1 + 8'd1, 8'h0F);
    chk("R3 active ch_en unchanged", act_ch_en, 0);
    rd(B1 + 8'd1, d);
    chk("R3 inactive bank holds write", d, 8'h0F);
  endtask

  task automatic t_no_arm();
    wr(B0, 8'h00);
    chk("R5 active fshape write no arm", switch_pending, 0);
    sync_pulse();
    chk("R5 idle sync keeps bank", active_bank, 0);
  endtask

  task automatic t_switch();
    logic [7:0] d;
    wr(B1, 8'h09);
    chk("R4 pending set", switch_pending, 1);
    chk("R4 no switch before sync", active_bank, 0);
    chk("R3 rows unchanged", frame_rows, 48);
    wr(B1, 8'h1B);
    sync_pulse();
    chk("R4 bank flipped", active_bank, 1);
    chk("R4 pending cleared", switch_pending, 0);
    chk("R6 last rows", frame_rows, 64);
    chk("R6 last cols", frame_cols, 8);
    chk("R4 bank1 ch_en active", act_ch_en, 8'h0F);
    rd(B0 + 8'd2, d);
    chk("R13 old bank retained", d, 8'h2F);
  endtask

  task automatic t_decode();
    for (int r = 0; r < 32; r++) begin
      wr(B1, 8'((r << 3) | (r % 8)));
      chk("R8 rows", frame_rows, exp_rows(r));
      chk("R7 cols", frame_cols, 2 * ((r % 8) + 1));
    end
    chk("R5 decode sweep no arm", switch_pending, 0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0;
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = B1 + 8'd1;
    @(negedge clk);
    chk("R12 rsp valid", rsp_valid, 1);
    chk("R12 ready low", acc_ready, 0);
    acc_write = 1'b1; acc_wdata = 8'hC3;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    chk("R12 data stable", rsp_data, 8'h0F);
    chk("R12 stalled write dropped", act_ch_en, 8'h0F);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R12 rsp released", rsp_valid, 0);
  endtask

  task automatic t_port0();
    logic [7:0] d;
    wr(B1 + 8'd7, 8'h55);
    chk("R11 port1 bpkg", act_blk_pkg, 8'h55);
    chk("R11 port0 bpkg ignored", z_act_blk_pkg, 0);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = B1 + 8'd7;
    @(negedge clk);
    acc_valid = 1'b0;
    d = z_rsp_data;
    chk("R11 port0 bpkg reads 0", d, 0);
  endtask

  task automatic t_switch_back();
    wr(B0, 8'h00);
    sync_pulse();
    chk("R4 back to bank0", active_bank, 0);
    chk("R13 bank0 si kept", act_sample_interval, 16'h012F);
    chk("R13 bank0 ch_en", act_ch_en, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_inactive();
    t_no_arm();
    t_switch();
    t_decode();
    t_backpressure();
    t_port0();
    t_switch_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule